// File: doc/BRIEF.md
# Reference Clock Frequency Detector

This block works out which of six standard oscillator frequencies drives its reference clock input. A free-running gate is built in the 32.768 kHz real-time-clock domain. It stays high for a set number of RTC cycles and then low for the same number. The gate is passed into the reference domain through a two-flop synchronizer. There the block counts reference cycles across one high phase of the gate and compares the count with a window around the nominal count for each table entry.

The result is a registered frequency index and a valid flag. The block also gives two fixed-point divider words that the frequency synthesizer uses to place its first local oscillator near 1573 MHz and its second at 3 MHz. Those frequencies give intermediate frequencies of 2 MHz and 1 MHz whatever oscillator is fitted.

One detection runs by itself when reset is released. Each later start pulse, taken while the block is idle, runs another. Outputs hold steady between runs, so the synthesizer can load them whenever the done flag is high.

Top module: `refclk_freq_detect`

## Requirements
- R1: Reset is synchronous and active high, and the reset state is done=0, valid=0, freq_idx=3, with both divider words belonging to entry 3. After reset is released, one detection starts with no start pulse.
- R2: The gate is high for GATE_CYCLES RTC cycles and then low for GATE_CYCLES RTC cycles. The count is the number of reference-clock cycles in which the synchronized gate is high, taken over the first complete high phase that follows arming.
- R3: Index encoding is 0=13.000, 1=14.400, 2=16.368, 3=18.414, 4=19.800 and 5=26.000 MHz. Entry i has a nominal count N = floor(f_i*GATE_CYCLES/32768). When the count lies within N ± floor(N*TOL_PERMILLE/1000) (0.5 % by default), the result is valid=1 and freq_idx=i.
- R4: When no entry matches, valid=0 and freq_idx=3, and the divider words are those of entry 3 (18.414 MHz).
- R5: For the reported entry, rf_div_word = round(1573e6*2^8/f) and if_div_word = round(3e6*2^8/f). Each word is unsigned and has 8 fractional bits.
- R6: A start pulse taken while idle drives done and valid low on the next clock edge. A new result follows after the next full gate window.
- R7: done rises only on the edge right after a measurement ends. While done stays high, freq_idx, valid and both divider words do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference oscillator clock under test; clocks the result logic |
| rtc_clk | input | 1 | 32.768 kHz real-time clock that times the gate |
| rst | input | 1 | Synchronous active-high reset (ref_clk domain, resynchronized for RTC logic) |
| start | input | 1 | Request for a new detection, taken while idle |
| done | output | 1 | Result registers hold a finished detection |
| valid | output | 1 | The last detection matched a table entry |
| freq_idx | output | IDX_W (3) | Index of the matched entry, 3 when no match |
| rf_div_word | output | WORD_W (16) | First local oscillator divider word, 8 fractional bits |
| if_div_word | output | WORD_W (16) | Second local oscillator divider word, 8 fractional bits |

## Verification
The bench drives every table frequency and also references 0.3 % off nominal, which must still match. A design whose tolerance window is too narrow, or that counts one gate edge too many, would drop those cases. References 1 % off and 22 MHz must give valid low with the 18.414 MHz index and words kept; a design with overlapping or missing windows would report a neighbour entry instead. The bench checks that done and valid fall right after start and that the outputs stay frozen while done is high. A design that loaded partial counts, or re-armed on a gate that was already high, would change its outputs or report the wrong entry.

// File: rtl/refdet_pkg.sv
package refdet_pkg;

  localparam int NUM_REF     = 6;
  localparam int DEFAULT_REF = 3;

  typedef enum logic [1:0] {
    MS_IDLE,
    MS_ARMED,
    MS_GATE
  } meas_state_e;

  // Nominal frequency of each table entry in Hz.
  function automatic longint ref_hz(input int idx);
    case (idx)
      0:       return 64'sd13000000;
      1:       return 64'sd14400000;
      2:       return 64'sd16368000;
      3:       return 64'sd18414000;
      4:       return 64'sd19800000;
      default: return 64'sd26000000;
    endcase
  endfunction

  function automatic longint nominal_count(input int idx, input int gate, input longint rtc_hz);
    return (ref_hz(idx) * longint'(gate)) / rtc_hz;
  endfunction

  function automatic longint count_slack(input int idx, input int gate, input longint rtc_hz,
                                         input int permille);
    return (nominal_count(idx, gate, rtc_hz) * longint'(permille)) / 64'sd1000;
  endfunction

  // Rounded fixed-point ratio lo_hz / f with frac fractional bits.
  function automatic longint lo_word(input longint lo_hz, input int frac, input int idx);
    return ((lo_hz <<< frac) + ref_hz(idx) / 2) / ref_hz(idx);
  endfunction

  // Counter width: room for the highest window limit plus one bit of headroom.
  function automatic int count_bits(input int gate, input longint rtc_hz, input int permille);
    longint top;
    top = 0;
    for (int i = 0; i < NUM_REF; i++) begin
      if (nominal_count(i, gate, rtc_hz) + count_slack(i, gate, rtc_hz, permille) > top)
        top = nominal_count(i, gate, rtc_hz) + count_slack(i, gate, rtc_hz, permille);
    end
    return $clog2(top + 1) + 1;
  endfunction

endpackage

// File: rtl/refdet_sync.sv
module refdet_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/refdet_gate_gen.sv
module refdet_gate_gen #(
  parameter  int GATE_CYCLES = 32,
  localparam int PH_W        = (GATE_CYCLES > 1) ? $clog2(GATE_CYCLES) : 1
) (
  input  logic rtc_clk,
  input  logic rtc_rst,
  output logic gate
);

  localparam logic [PH_W-1:0] PH_LAST = PH_W'(GATE_CYCLES - 1);

  logic [PH_W-1:0] phase;

  // Registered square wave: GATE_CYCLES high, GATE_CYCLES low.
  always_ff @(posedge rtc_clk) begin
    if (rtc_rst) begin
      phase <= '0;
      gate  <= 1'b0;
    end else if (phase == PH_LAST) begin
      phase <= '0;
      gate  <= ~gate;
    end else begin
      phase <= phase + 1'b1;
    end
  end

endmodule

// File: rtl/refdet_meas.sv
module refdet_meas
  import refdet_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             gate_s,
  output logic             start_acc,
  output logic             meas_done,
  output logic [CNT_W-1:0] count
);

  meas_state_e state;
  logic        gate_d;
  logic        rise;
  logic        fall;

  assign rise      = gate_s & ~gate_d;
  assign fall      = ~gate_s & gate_d;
  assign start_acc = start && (state == MS_IDLE);

  // gate_d resets high so a gate already high at arming is never taken as a rise.
  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= MS_ARMED;
      gate_d    <= 1'b1;
      meas_done <= 1'b0;
      count     <= '0;
    end else begin
      gate_d    <= gate_s;
      meas_done <= 1'b0;
      case (state)
        MS_IDLE: begin
          if (start) state <= MS_ARMED;
        end
        MS_ARMED: begin
          if (rise) begin
            count <= CNT_W'(1);
            state <= MS_GATE;
          end
        end
        MS_GATE: begin
          if (fall) begin
            meas_done <= 1'b1;
            state     <= MS_IDLE;
          end else if (count != '1) begin
            count <= count + 1'b1;
          end
        end
        default: state <= MS_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/refdet_classify.sv
module refdet_classify
  import refdet_pkg::*;
#(
  parameter  int     GATE_CYCLES  = 32,
  parameter  int     RTC_HZ       = 32768,
  parameter  int     TOL_PERMILLE = 5,
  parameter  int     CNT_W        = 16,
  parameter  int     WORD_W       = 16,
  parameter  int     FRAC_BITS    = 8,
  parameter  longint LO1_HZ       = 64'sd1573000000,
  parameter  longint LO2_HZ       = 64'sd3000000,
  localparam int     IDX_W        = $clog2(NUM_REF)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              load,
  input  logic [CNT_W-1:0]  count,
  output logic              done,
  output logic              valid,
  output logic [IDX_W-1:0]  idx,
  output logic [WORD_W-1:0] rf_word,
  output logic [WORD_W-1:0] if_word
);

  logic [NUM_REF-1:0] hit;
  logic [WORD_W-1:0]  rf_tab [NUM_REF];
  logic [WORD_W-1:0]  if_tab [NUM_REF];
  logic [IDX_W-1:0]   pick;
  logic               found;

  for (genvar g = 0; g < NUM_REF; g++) begin : g_ref
    localparam longint NOM = nominal_count(g, GATE_CYCLES, longint'(RTC_HZ));
    localparam longint SLK = count_slack(g, GATE_CYCLES, longint'(RTC_HZ), TOL_PERMILLE);
    localparam logic [CNT_W-1:0] LO_LIM = CNT_W'(NOM - SLK);
    localparam logic [CNT_W-1:0] HI_LIM = CNT_W'(NOM + SLK);

    assign hit[g]    = (count >= LO_LIM) && (count <= HI_LIM);
    assign rf_tab[g] = WORD_W'(lo_word(LO1_HZ, FRAC_BITS, g));
    assign if_tab[g] = WORD_W'(lo_word(LO2_HZ, FRAC_BITS, g));
  end

  // Lowest matching index wins; windows do not overlap at legal settings.
  always_comb begin
    pick  = IDX_W'(DEFAULT_REF);
    found = 1'b0;
    for (int i = NUM_REF - 1; i >= 0; i--) begin
      if (hit[i]) begin
        pick  = IDX_W'(i);
        found = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done    <= 1'b0;
      valid   <= 1'b0;
      idx     <= IDX_W'(DEFAULT_REF);
      rf_word <= rf_tab[DEFAULT_REF];
      if_word <= if_tab[DEFAULT_REF];
    end else if (load) begin
      done    <= 1'b1;
      valid   <= found;
      idx     <= pick;
      rf_word <= rf_tab[pick];
      if_word <= if_tab[pick];
    end else if (clear) begin
      done  <= 1'b0;
      valid <= 1'b0;
    end
  end

endmodule

// File: rtl/refclk_freq_detect.sv
module refclk_freq_detect
  import refdet_pkg::*;
#(
  parameter  int     GATE_CYCLES  = 32,
  parameter  int     RTC_HZ       = 32768,
  parameter  int     TOL_PERMILLE = 5,
  parameter  int     WORD_W       = 16,
  parameter  int     FRAC_BITS    = 8,
  parameter  longint LO1_HZ       = 64'sd1573000000,
  parameter  longint LO2_HZ       = 64'sd3000000,
  parameter  int     SYNC_STAGES  = 2,
  localparam int     IDX_W        = $clog2(NUM_REF)
) (
  input  logic              ref_clk,
  input  logic              rtc_clk,
  input  logic              rst,
  input  logic              start,
  output logic              done,
  output logic              valid,
  output logic [IDX_W-1:0]  freq_idx,
  output logic [WORD_W-1:0] rf_div_word,
  output logic [WORD_W-1:0] if_div_word
);

  localparam int CNT_W = count_bits(GATE_CYCLES, longint'(RTC_HZ), TOL_PERMILLE);

  logic             rtc_rst;
  logic             gate_rtc;
  logic             gate_s;
  logic             start_acc;
  logic             meas_done;
  logic [CNT_W-1:0] count;

  refdet_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk (rtc_clk),
    .d   (rst),
    .q   (rtc_rst)
  );

  refdet_gate_gen #(.GATE_CYCLES(GATE_CYCLES)) u_gate (
    .rtc_clk (rtc_clk),
    .rtc_rst (rtc_rst),
    .gate    (gate_rtc)
  );

  refdet_sync #(.STAGES(SYNC_STAGES)) u_gate_sync (
    .clk (ref_clk),
    .d   (gate_rtc),
    .q   (gate_s)
  );

  refdet_meas #(.CNT_W(CNT_W)) u_meas (
    .clk       (ref_clk),
    .rst       (rst),
    .start     (start),
    .gate_s    (gate_s),
    .start_acc (start_acc),
    .meas_done (meas_done),
    .count     (count)
  );

  refdet_classify #(
    .GATE_CYCLES  (GATE_CYCLES),
    .RTC_HZ       (RTC_HZ),
    .TOL_PERMILLE (TOL_PERMILLE),
    .CNT_W        (CNT_W),
    .WORD_W       (WORD_W),
    .FRAC_BITS    (FRAC_BITS),
    .LO1_HZ       (LO1_HZ),
    .LO2_HZ       (LO2_HZ)
  ) u_class (
    .clk     (ref_clk),
    .rst     (rst),
    .clear   (start_acc),
    .load    (meas_done),
    .count   (count),
    .done    (done),
    .valid   (valid),
    .idx     (freq_idx),
    .rf_word (rf_div_word),
    .if_word (if_div_word)
  );

endmodule

// File: rtl/refclk_freq_detect_chk.sv
module refclk_freq_detect_chk
  import refdet_pkg::*;
#(
  parameter int IDX_W  = 3,
  parameter int WORD_W = 16
) (
  input logic              ref_clk,
  input logic              rst,
  input logic              start_acc,
  input logic              meas_done,
  input logic              done,
  input logic              valid,
  input logic [IDX_W-1:0]  freq_idx,
  input logic [WORD_W-1:0] rf_div_word,
  input logic [WORD_W-1:0] if_div_word
);

  // R3
  valid_idx_chk: assert property (@(posedge ref_clk) disable iff (rst)
    valid |-> (freq_idx < IDX_W'(NUM_REF)));

  // R4
  nomatch_default_chk: assert property (@(posedge ref_clk) disable iff (rst)
    (done && !valid) |-> (freq_idx == IDX_W'(DEFAULT_REF)));

  // R6
  valid_needs_done_chk: assert property (@(posedge ref_clk) disable iff (rst)
    valid |-> done);

  // R6
  start_clears_chk: assert property (@(posedge ref_clk) disable iff (rst)
    start_acc |=> (!done && !valid));

  // R7
  done_source_chk: assert property (@(posedge ref_clk) disable iff (rst)
    $rose(done) |-> $past(meas_done));

  // R7
  hold_stable_chk: assert property (@(posedge ref_clk) disable iff (rst)
    (done && $past(done)) |-> ($stable(freq_idx) && $stable(valid) &&
                               $stable(rf_div_word) && $stable(if_div_word)));

endmodule

bind refclk_freq_detect refclk_freq_detect_chk #(
  .IDX_W  (IDX_W),
  .WORD_W (WORD_W)
) u_chk (
  .ref_clk     (ref_clk),
  .rst         (rst),
  .start_acc   (start_acc),
  .meas_done   (meas_done),
  .done        (done),
  .valid       (valid),
  .freq_idx    (freq_idx),
  .rf_div_word (rf_div_word),
  .if_div_word (if_div_word)
);

// File: tb/refclk_freq_detect_bench.sv
`timescale 1ns/1ps
module refclk_freq_detect_bench;

  localparam int     GATE = 4;
  localparam longint LO1  = 64'sd1573000000;
  localparam longint LO2  = 64'sd3000000;
  localparam int     NV   = 10;

  localparam longint NOM_HZ [6] = '{64'sd13000000, 64'sd14400000, 64'sd16368000,
                                    64'sd18414000, 64'sd19800000, 64'sd26000000};

  // Stimulus frequency, expected valid, expected index.
  localparam longint VEC_HZ  [NV] = '{64'sd13000000, 64'sd14400000, 64'sd16368000,
                                      64'sd18414000, 64'sd19800000, 64'sd26000000,
                                      64'sd13039000, 64'sd19740600, 64'sd16531680,
                                      64'sd22000000};
  localparam bit     VEC_OK  [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1,
                                      1'b1, 1'b1, 1'b0, 1'b0};
  localparam int     VEC_IDX [NV] = '{0, 1, 2, 3, 4, 5, 0, 4, 3, 3};

  logic        ref_clk;
  logic        rtc_clk;
  logic        rst;
  logic        start;
  logic        done;
  logic        valid;
  logic [2:0]  freq_idx;
  logic [15:0] rf_div_word;
  logic [15:0] if_div_word;

  int  n_chk  = 0;
  int  n_fail = 0;
  real rtc_half = 2.5 * 18414000.0 / 32768.0;

  refclk_freq_detect #(.GATE_CYCLES(GATE)) u_refclk_freq_detect (
    .ref_clk     (ref_clk),
    .rtc_clk     (rtc_clk),
    .rst         (rst),
    .start       (start),
    .done        (done),
    .valid       (valid),
    .freq_idx    (freq_idx),
    .rf_div_word (rf_div_word),
    .if_div_word (if_div_word)
  );

  initial begin
    ref_clk = 1'b0;
    forever #2.5 ref_clk = ~ref_clk;
  end

  // RTC period set so that one RTC cycle spans f/32768 cycles of the 200 MHz clock.
  initial begin
    rtc_clk = 1'b0;
    forever begin
      #(rtc_half);
      rtc_clk = ~rtc_clk;
    end
  end

  function automatic longint word_of(input longint lo, input longint f);
    return ((lo <<< 8) + f / 2) / f;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic set_ref(input longint hz);
    rtc_half = 2.5 * real'(hz) / 32768.0;
  endtask

  task automatic wait_done(input string req);
    int n;
    n = 0;
    while (!done && n < 30000) begin
      @(negedge ref_clk);
      n++;
    end
    chk(done, req, "done timeout", longint'(done), 1);
  endtask

  task automatic pulse_start();
    @(negedge ref_clk) start = 1'b1;
    @(negedge ref_clk) start = 1'b0;
  endtask

  task automatic check_result(input string req, input bit exp_ok, input int exp_idx);
    chk(valid == exp_ok, req, "valid", longint'(valid), longint'(exp_ok));
    chk(freq_idx == 3'(exp_idx), req, "freq_idx", longint'(freq_idx), longint'(exp_idx));
    // R5
    chk(rf_div_word == 16'(word_of(LO1, NOM_HZ[exp_idx])), "R5", "rf_div_word",
        longint'(rf_div_word), word_of(LO1, NOM_HZ[exp_idx]));
    chk(if_div_word == 16'(word_of(LO2, NOM_HZ[exp_idx])), "R5", "if_div_word",
        longint'(if_div_word), word_of(LO2, NOM_HZ[exp_idx]));
  endtask

  initial begin
    repeat (190000) @(posedge ref_clk);
    n_fail++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [2:0]  hold_idx;
    logic [15:0] hold_rf;
    logic [15:0] hold_if;
    logic        hold_valid;

    rst   = 1'b1;
    start = 1'b0;
    repeat (1500) @(posedge ref_clk);
    @(negedge ref_clk) rst = 1'b0;
    @(negedge ref_clk);

    // R1 reset state
    chk(!done, "R1", "done after reset", longint'(done), 0);
    chk(!valid, "R1", "valid after reset", longint'(valid), 0);
    chk(freq_idx == 3'd3, "R1", "freq_idx after reset", longint'(freq_idx), 3);
    chk(rf_div_word == 16'(word_of(LO1, NOM_HZ[3])), "R1", "rf word after reset",
        longint'(rf_div_word), word_of(LO1, NOM_HZ[3]));
    chk(if_div_word == 16'(word_of(LO2, NOM_HZ[3])), "R1", "if word after reset",
        longint'(if_div_word), word_of(LO2, NOM_HZ[3]));

    // R1 automatic first detection at 18.414 MHz
    wait_done("R1");
    check_result("R1", 1'b1, 3);

    // R2 R3 R4: table walk
    for (int v = 0; v < NV; v++) begin
      set_ref(VEC_HZ[v]);
      #(6.0 * rtc_half);
      pulse_start();
      // R6
      chk(!done, "R6", "done after start", longint'(done), 0);
      chk(!valid, "R6", "valid after start", longint'(valid), 0);
      wait_done("R2");
      check_result(VEC_OK[v] ? "R3" : "R4", VEC_OK[v], VEC_IDX[v]);
    end

    // R7: outputs frozen while done stays high
    hold_idx   = freq_idx;
    hold_rf    = rf_div_word;
    hold_if    = if_div_word;
    hold_valid = valid;
    repeat (3000) @(negedge ref_clk);
    chk(done, "R7", "done held", longint'(done), 1);
    chk(freq_idx == hold_idx, "R7", "freq_idx held", longint'(freq_idx), longint'(hold_idx));
    chk(valid == hold_valid, "R7", "valid held", longint'(valid), longint'(hold_valid));
    chk(rf_div_word == hold_rf, "R7", "rf word held", longint'(rf_div_word), longint'(hold_rf));
    chk(if_div_word == hold_if, "R7", "if word held", longint'(if_div_word), longint'(hold_if));

    // R6 R3: recovery from a no-match to a valid match
    set_ref(64'sd14400000);
    #(6.0 * rtc_half);
    pulse_start();
    chk(!done, "R6", "done after restart", longint'(done), 0);
    wait_done("R6");
    check_result("R3", 1'b1, 1);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule